// File: doc/BRIEF.md
# Wakeup Event Latch Unit

This unit gathers wake events from two groups of sources, one coming from external pins and one from internal interrupt lines. Each source is passed through a two-flop synchroniser and then through an edge detector whose direction is programmable per bit. A detected edge sets a sticky latch bit. The latch is set whether or not the source is enabled. The enable bits only decide whether a latched event counts toward the masked status and the wake request.

Software reaches the unit over a simple register bus with combinational reads. Each group has an enable, a polarity, a raw latch and a masked status register. Latch bits are cleared by writing ones. The wake request output is registered. It stays high while any enabled latch bit in either group is set.

Top module: `wk_unit`

## Requirements
- R1: After reset all enable bits and all latch bits are 0 and wake_req is 0. Pin polarity resets to 0x00000000. Internal polarity resets to the parameter INT_POL_RST, which has the default 0x00000007 (three rising-edge sources).
- R2: A polarity bit of 1 latches a rising edge of its source, and a polarity bit of 0 latches a falling edge. The opposite edge leaves the latch bit at 0.
- R3: A latch bit is set by its edge even when its enable bit is 0, and it stays set after its enable bit is cleared.
- R4: Masked status reads as raw latch AND enable. The masked status register is read-only, so a write to it changes neither enable nor raw.
- R5: Writing to a raw latch register clears exactly the bits written as 1 and keeps the other bits. Writing back a value just read from it clears every latch bit that value contained.
- R6: An edge detected in the same cycle as a clear write to its bit leaves the bit set.
- R7: wake_req is the registered OR of both groups' masked status. It rises one cycle after an enabled latch bit becomes visible. It falls one cycle after the last enabled latch bit is cleared or disabled.
- R8: The groups are independent. An edge on a source in one group, or a write to one group's registers, leaves the other group's latch bits unchanged.
- R9: A source change applied between clock edges becomes visible in its raw latch bit after the third following rising clock edge. Two edges are for synchronisation and one is for the edge compare.
- R10: Byte address bit 4 selects the group (0 pin, 1 internal). Bits 3:2 select the register: 0 enable, 1 polarity, 2 raw latch, 3 masked status. Bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_src | input | N_SRC | Asynchronous pin event sources |
| int_src | input | N_SRC | Asynchronous internal event sources |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | N_SRC | Write data |
| bus_rdata | output | N_SRC | Read data, valid in the cycle of bus_sel with bus_we low |
| wake_req | output | 1 | Registered wake request |

## Verification
The hardest case to reach from the ports is the collision between a freshly detected edge and a clear write to the same bit. The edge exists only in the single cycle after the synchroniser output changes. The stimulus drives the source between edges and waits exactly one clock. It then issues the clear write so that the write lands on the third edge, which is the edge-compare cycle, with the latch bit already set from an earlier event. If the clear won over the edge, the bit would read back as 0. The bench also follows the R9 latency one cycle at a time to pin down where raw and wake_req each change.

// File: rtl/wk_pkg.sv
package wk_pkg;
    typedef enum logic [1:0] {
        REG_EN  = 2'd0,
        REG_POL = 2'd1,
        REG_RAW = 2'd2,
        REG_MSK = 2'd3
    } wk_reg_e;

    localparam int unsigned NUM_GROUPS = 2;
    localparam int unsigned ADDR_W     = 5;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (rst) stg_q[i] <= '0;
            else     stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/wk_edge.sv
module wk_edge #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] pol,
    output logic [WIDTH-1:0] evt
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // rising when polarity is 1, falling when polarity is 0
    assign evt = (pol & lvl & ~st_q.prev) | (~pol & ~lvl & st_q.prev);
endmodule

// File: rtl/wk_group.sv
module wk_group #(
    parameter int unsigned     WIDTH       = 32,
    parameter int unsigned     SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] POL_RST    = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] src,
    input  logic             wr_en,
    input  logic             wr_pol,
    input  logic             wr_clr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] en,
    output logic [WIDTH-1:0] pol,
    output logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] msk
);
    typedef struct packed {
        logic [WIDTH-1:0] en;
        logic [WIDTH-1:0] pol;
        logic [WIDTH-1:0] raw;
    } grp_state_t;

    grp_state_t       st_d, st_q;
    logic [WIDTH-1:0] lvl;
    logic [WIDTH-1:0] evt;
    logic [WIDTH-1:0] clr;

    wk_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (src),
        .dout (lvl)
    );

    wk_edge #(.WIDTH(WIDTH)) u_edge (
        .clk (clk),
        .rst (rst),
        .lvl (lvl),
        .pol (st_q.pol),
        .evt (evt)
    );

    assign clr = wr_clr ? wdata : '0;

    always_comb begin
        st_d = st_q;
        if (wr_en)  st_d.en  = wdata;
        if (wr_pol) st_d.pol = wdata;
        // a new edge wins over a clear of the same bit
        st_d.raw = (st_q.raw & ~clr) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.en  <= '0;
            st_q.pol <= POL_RST;
            st_q.raw <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en  = st_q.en;
    assign pol = st_q.pol;
    assign raw = st_q.raw;
    assign msk = st_q.raw & st_q.en;

    // R5: a latch bit only falls where a clear was written
    p_clear_only_r5: assert property (@(posedge clk) disable iff (rst)
        ((~raw & $past(raw) & ~$past(clr)) == '0));

    // R6: an edge coinciding with a clear leaves the bit set
    p_race_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (($past(evt & clr) & ~raw) == '0));

    // R3: an edge latches whatever the enable
    p_latch_any_r3: assert property (@(posedge clk) disable iff (rst)
        (($past(evt) & ~raw) == '0));
endmodule

// File: rtl/wk_unit.sv
module wk_unit
    import wk_pkg::*;
#(
    parameter int unsigned      N_SRC       = 32,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter logic [N_SRC-1:0] PIN_POL_RST = '0,
    parameter logic [N_SRC-1:0] INT_POL_RST = N_SRC'(32'h0000_0007)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  pin_src,
    input  logic [N_SRC-1:0]  int_src,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [N_SRC-1:0]  bus_rdata,
    output logic              wake_req
);
    typedef struct packed {
        logic wake;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic [N_SRC-1:0] src_v [NUM_GROUPS];
    logic [N_SRC-1:0] en_v  [NUM_GROUPS];
    logic [N_SRC-1:0] pol_v [NUM_GROUPS];
    logic [N_SRC-1:0] raw_v [NUM_GROUPS];
    logic [N_SRC-1:0] msk_v [NUM_GROUPS];
    logic             grp_sel;
    wk_reg_e          reg_sel;
    logic             wr_any;
    logic             any_msk;

    assign src_v[0] = pin_src;
    assign src_v[1] = int_src;
    assign grp_sel  = bus_addr[4];
    assign reg_sel  = wk_reg_e'(bus_addr[3:2]);
    assign wr_any   = bus_sel & bus_we;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam logic [N_SRC-1:0] POL_INIT = (g == 0) ? PIN_POL_RST : INT_POL_RST;
        logic hit;
        assign hit = wr_any & (grp_sel == (g == 1));

        wk_group #(
            .WIDTH       (N_SRC),
            .SYNC_STAGES (SYNC_STAGES),
            .POL_RST     (POL_INIT)
        ) u_group (
            .clk    (clk),
            .rst    (rst),
            .src    (src_v[g]),
            .wr_en  (hit & (reg_sel == REG_EN)),
            .wr_pol (hit & (reg_sel == REG_POL)),
            .wr_clr (hit & (reg_sel == REG_RAW)),
            .wdata  (bus_wdata),
            .en     (en_v[g]),
            .pol    (pol_v[g]),
            .raw    (raw_v[g]),
            .msk    (msk_v[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (reg_sel)
                REG_EN:  bus_rdata = en_v [grp_sel];
                REG_POL: bus_rdata = pol_v[grp_sel];
                REG_RAW: bus_rdata = raw_v[grp_sel];
                default: bus_rdata = msk_v[grp_sel];
            endcase
        end
    end

    assign any_msk = |(msk_v[0] | msk_v[1]);

    always_comb begin
        st_d      = st_q;
        st_d.wake = any_msk;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wake_req = st_q.wake;

    // R7: an enabled latched event raises wake on the next cycle
    p_wake_follow_r7: assert property (@(posedge clk) disable iff (rst)
        any_msk |=> wake_req);

    // R7: wake is high only with a masked event one cycle earlier
    p_wake_cause_r7: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> $past(any_msk));

    // R4: writing the masked status leaves the enables alone
    p_rdonly_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && reg_sel == REG_MSK) |=>
            ($stable(en_v[0]) && $stable(en_v[1])));
endmodule

// File: tb/tb_wk_unit.sv
module tb_wk_unit;
    localparam int N = 32;
    localparam logic [4:0] A_PEN = 5'h00, A_PPOL = 5'h04, A_PRAW = 5'h08, A_PMSK = 5'h0C;
    localparam logic [4:0] A_IEN = 5'h10, A_IPOL = 5'h14, A_IRAW = 5'h18, A_IMSK = 5'h1C;

    typedef struct packed {
        logic       grp;
        logic [4:0] idx;
        logic       pol;
        logic       lv0;
        logic       lv1;
        logic       en;
        logic       exp_raw;
        logic       exp_wake;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 5'd3,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        '{1'b0, 5'd3,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b0, 5'd31, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b0, 5'd0,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 5'd5,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        '{1'b1, 5'd5,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 5'd30, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b1, 5'd0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pin_src = '0;
    logic [N-1:0] int_src = '0;
    logic         bus_sel = 1'b0;
    logic         bus_we = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic         wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wk_unit dut (
        .clk(clk), .rst(rst), .pin_src(pin_src), .int_src(int_src),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_req(wake_req)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic clear_all();
        wr(A_PRAW, '1);
        wr(A_IRAW, '1);
    endtask

    initial begin
        logic [N-1:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_PEN, d);  check("R1 pin enable", d, '0);
        rd(A_IEN, d);  check("R1 int enable", d, '0);
        rd(A_PPOL, d); check("R1 pin polarity", d, '0);
        rd(A_IPOL, d); check("R1 int polarity", d, 32'h0000_0007);
        rd(A_PRAW, d); check("R1 pin raw", d, '0);
        rd(A_IRAW, d); check("R1 int raw", d, '0);
        rd(A_IMSK, d); check("R1 int masked", d, '0);
        check("R1 wake", {31'd0, wake_req}, '0);

        // table walk: R2 R3 R4 R7 R8 R10
        for (int i = 0; i < 8; i++) begin
            vec_t v = VEC[i];
            logic [N-1:0] m = 32'd1 << v.idx;
            logic [4:0] base = v.grp ? 5'h10 : 5'h00;
            wr(base + 5'h04, v.pol ? m : '0);
            wr(base, v.en ? m : '0);
            if (v.grp) int_src = v.lv0 ? m : '0; else pin_src = v.lv0 ? m : '0;
            settle();
            clear_all();
            settle();
            if (v.grp) int_src = v.lv1 ? m : '0; else pin_src = v.lv1 ? m : '0;
            settle();
            rd(base + 5'h08, d);
            check($sformatf("R2 R3 vec%0d raw", i), d, v.exp_raw ? m : '0);
            rd(base + 5'h0C, d);
            check($sformatf("R4 vec%0d masked", i), d, (v.exp_raw && v.en) ? m : '0);
            rd(v.grp ? A_PRAW : A_IRAW, d);
            check($sformatf("R8 vec%0d other group raw", i), d, '0);
            check($sformatf("R7 vec%0d wake", i), {31'd0, wake_req}, {31'd0, v.exp_wake});
            pin_src = '0; int_src = '0;
            settle();
            wr(A_PEN, '0); wr(A_IEN, '0);
            clear_all();
        end

        // R5 selective and write-back clear
        wr(A_PPOL, 32'h84);
        pin_src = 32'h84;
        settle();
        rd(A_PRAW, d); check("R5 two bits latched", d, 32'h84);
        wr(A_PRAW, 32'h04);
        rd(A_PRAW, d); check("R5 only written bit cleared", d, 32'h80);
        // R4 masked status is read-only
        wr(A_PMSK, '1);
        rd(A_PEN, d);  check("R4 enable after masked write", d, '0);
        rd(A_PRAW, d); check("R4 raw after masked write", d, 32'h80);
        rd(A_PRAW, d);
        wr(A_PRAW, d);
        rd(A_PRAW, d); check("R5 write-back clears", d, '0);
        pin_src = '0;
        settle();
        clear_all();

        // R9 latency and R7 timing
        wr(A_IPOL, 32'h2); wr(A_IEN, 32'h2);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = A_IRAW;
        int_src = 32'h2;
        @(negedge clk); #1 check("R9 raw after edge 1", bus_rdata, '0);
        @(negedge clk); #1 check("R9 raw after edge 2", bus_rdata, '0);
        @(negedge clk); #1 check("R9 raw after edge 3", bus_rdata, 32'h2);
        check("R7 wake not yet", {31'd0, wake_req}, '0);
        @(negedge clk); #1 check("R7 wake after edge 4", {31'd0, wake_req}, 32'd1);
        bus_sel = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 wake held", {31'd0, wake_req}, 32'd1);
        wr(A_IEN, '0);
        @(negedge clk);
        check("R7 wake drops after disable", {31'd0, wake_req}, '0);
        rd(A_IRAW, d); check("R3 latch kept while disabled", d, 32'h2);
        clear_all();

        // R6 edge coinciding with clear
        int_src = '0;
        settle();
        int_src = 32'h2;
        settle();
        rd(A_IRAW, d); check("R6 setup latch", d, 32'h2);
        int_src = '0;
        settle();
        @(negedge clk);
        int_src = 32'h2;
        @(negedge clk);
        wr(A_IRAW, 32'h2);
        rd(A_IRAW, d); check("R6 edge wins over clear", d, 32'h2);
        wr(A_IRAW, 32'h2);
        rd(A_IRAW, d); check("R6 later clear works", d, '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule